// File: doc/BRIEF.md
# Extended Hardware Stack Pointer

This block owns the stack pointer of an 8051-class processor core. In the classic configuration the pointer is a single 8-bit register that addresses the stack inside internal RAM. When the wide-stack control bit is set, a second register supplies two more address bits. The low two bits of that register act as a page number that carries when the low pointer overflows and borrows when it underflows, so the stack can span a 1 KB dedicated stack memory.

The core's decoder issues single-byte push and pop requests. It can also ask the block to save or restore a whole return address for a subroutine call, a return or an interrupt entry. The block then steps through the byte transfers on consecutive cycles. Return addresses are two bytes wide, or three bytes when 24-bit flat addressing is on. At the end of each sequence the block presents the value to load into the program counter. The stack memories sit outside the block and return read data one cycle after the read strobe.

Top module: `xstack_ptr`

## Requirements
- R1: After reset the low pointer reads 0x07, the extension register reads 0xFC, and the block is idle with no memory access, no pop data, no PC load and no conflict flag.
- R2: With the wide-stack bit clear, a push first increments the low pointer, with 0xFF wrapping to 0x00. It then writes the byte at address {2'b00, new pointer} with stk_ext_sel low. A pop reads at {2'b00, pointer} and then decrements the pointer. The extension register never changes in this mode.
- R3: With the wide-stack bit set, a push increments the low pointer. When the pointer wraps from 0xFF to 0x00, extension bits [1:0] increment modulo 4 and bits [7:2] are untouched. The byte is written at {ext[1:0], pointer} formed from the new values, with stk_ext_sel high.
- R4: With the wide-stack bit set, a pop reads at {ext[1:0], pointer} formed from the current values and then decrements the pointer. When the pointer wraps from 0x00 to 0xFF, extension bits [1:0] decrement modulo 4.
- R5: One cycle after any pop access, pop_valid is high and pop_data carries the byte the memory returned for that access.
- R6: When push_req and pop_req are both high, neither operation happens and no sequence starts. req_conflict is high in the next cycle.
- R7: A call request pushes the return address starting the cycle after the request: low byte first, then the high byte, then bits [23:16] as a third byte when flat mode is set. seq_busy is high during these cycles. In the cycle after the last push, pc_load_valid pulses with jump_target, whose bits [23:16] are forced to zero when flat mode is clear.
- R8: An interrupt request pushes the return address like a call. The value loaded afterwards is jump_target with bits [23:16] always forced to zero.
- R9: A return request pops one byte per cycle starting the cycle after the request: bits [23:16] first (flat mode only), then the high byte, then the low byte. pc_load_valid pulses two cycles after the last pop with upper*65536 + high*256 + low, where upper is zero when flat mode is clear.
- R10: While seq_busy is high, push, pop, call, interrupt and return requests are ignored.
- R11: When idle, a single push or pop takes precedence over a sequence request. Among sequence requests an interrupt wins over a call, and a call wins over a return.
- R12: A write to either pointer register takes effect at the next clock edge. If a stack movement happens in the same cycle, the written value replaces the value the movement would have produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stk_mode_10b | input | 1 | Selects the 10-bit stack in the dedicated memory |
| flat_24b | input | 1 | 24-bit flat addressing; return addresses are three bytes |
| push_req | input | 1 | Push one byte |
| pop_req | input | 1 | Pop one byte |
| push_data | input | 8 | Byte to push |
| call_req | input | 1 | Start a call sequence |
| irq_req | input | 1 | Start an interrupt entry sequence |
| ret_req | input | 1 | Start a return sequence |
| ret_addr | input | 24 | Return address to save on call or interrupt |
| jump_target | input | 24 | Call target or interrupt vector |
| sp_wr_en | input | 1 | Write the low pointer |
| sp_wr_data | input | 8 | Low pointer write value |
| esp_wr_en | input | 1 | Write the extension register |
| esp_wr_data | input | 8 | Extension register write value |
| stk_addr | output | 10 | Stack memory address |
| stk_ext_sel | output | 1 | High: dedicated 1 KB memory; low: internal RAM |
| stk_we | output | 1 | Stack write strobe |
| stk_wdata | output | 8 | Stack write data |
| stk_re | output | 1 | Stack read strobe |
| stk_rdata | input | 8 | Read data, one cycle after stk_re |
| pop_valid | output | 1 | pop_data is valid |
| pop_data | output | 8 | Popped byte |
| sp_value | output | 8 | Low pointer |
| esp_value | output | 8 | Extension register |
| seq_busy | output | 1 | A return-address sequence is running |
| pc_load_valid | output | 1 | One-cycle pulse: load pc_load_value into the PC |
| pc_load_value | output | 24 | Program counter value to load |
| req_conflict | output | 1 | Push and pop were requested together |

## Verification
The hardest case is a three-byte flat call that crosses a page boundary in the middle of the sequence. It involves the pointer wrap, the extension carry and the byte order all at once. A matching return must then borrow back across the same boundary and rebuild the address. The stimulus reaches this case by writing the pointer pair to 0xFE and page 1, and by placing the page at 3 so that it wraps to 0. It then issues the call and the return back to back. Requests are also injected while a sequence is busy, to confirm that they are dropped. A behavioural model with its own shadow memory checks every cycle.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PUSH  = 2'd1,
    SQ_POP   = 2'd2,
    SQ_DRAIN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/xsp_ptr_next.sv
// Pointer arithmetic for one stack movement: next low pointer, next page bits, access address.
module xsp_ptr_next #(
  parameter int SP_W  = 8,
  parameter int EXT_W = 2
) (
  input  logic [SP_W-1:0]       sp_cur,
  input  logic [EXT_W-1:0]      ext_cur,
  input  logic                  wide_mode,
  input  logic                  do_push,
  input  logic                  do_pop,
  output logic [SP_W-1:0]       sp_nxt,
  output logic [EXT_W-1:0]      ext_nxt,
  output logic [SP_W+EXT_W-1:0] acc_addr
);
  localparam int AW = SP_W + EXT_W;

  logic at_top;
  logic at_bot;

  assign at_top = &sp_cur;
  assign at_bot = ~|sp_cur;

  always_comb begin
    sp_nxt  = sp_cur;
    ext_nxt = ext_cur;
    if (do_push) begin
      sp_nxt = sp_cur + 1'b1;
      if (wide_mode && at_top) ext_nxt = ext_cur + 1'b1;
    end else if (do_pop) begin
      sp_nxt = sp_cur - 1'b1;
      if (wide_mode && at_bot) ext_nxt = ext_cur - 1'b1;
    end
  end

  // Push writes at the pre-incremented pointer; pop reads at the current one.
  always_comb begin
    if (do_push) begin
      acc_addr = wide_mode ? {ext_nxt, sp_nxt} : {{EXT_W{1'b0}}, sp_nxt};
    end else begin
      acc_addr = wide_mode ? {ext_cur, sp_cur} : {{EXT_W{1'b0}}, sp_cur};
    end
  end

  logic [AW-1:0] unused_chk;
  assign unused_chk = acc_addr;
endmodule

// File: rtl/xsp_seq.sv
// Return-address sequencer: byte-serial save and restore of the program counter.
module xsp_seq
  import xsp_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_call,
  input  logic              start_irq,
  input  logic              start_ret,
  input  logic              flat_mode,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic [PC_W-1:0]   target,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              seq_push,
  output logic              seq_pop,
  output logic [BYTE_W-1:0] push_byte,
  output logic              pc_valid,
  output logic [PC_W-1:0]   pc_value
);
  localparam int NB    = PC_W / BYTE_W;
  localparam int CNT_W = (NB > 2) ? $clog2(NB) : 1;
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(NB - 1);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(NB - 2);
  localparam logic [PC_W-1:0]  SHORT_MASK = {{BYTE_W{1'b0}}, {(PC_W-BYTE_W){1'b1}}};

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PC_W-1:0]   sh_q, sh_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              pcv_q, pcv_d;
  logic              sh_en, pc_en, cnt_en;
  logic              capture;

  assign capture = rd_valid && ((state_q == SQ_POP) || (state_q == SQ_DRAIN));

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    pc_d     = pc_q;
    pcv_d    = 1'b0;
    seq_push = 1'b0;
    seq_pop  = 1'b0;
    sh_en    = 1'b0;
    pc_en    = 1'b0;
    cnt_en   = 1'b0;
    if (capture) begin
      pc_d  = {pc_q[PC_W-BYTE_W-1:0], rd_data};
      pc_en = 1'b1;
    end
    unique case (state_q)
      SQ_IDLE: begin
        if (start_irq || start_call) begin
          state_d = SQ_PUSH;
          cnt_d   = flat_mode ? CNT_LONG : CNT_SHORT;
          cnt_en  = 1'b1;
          sh_d    = ret_addr;
          sh_en   = 1'b1;
          pc_d    = (start_call && flat_mode) ? target : (target & SHORT_MASK);
          pc_en   = 1'b1;
        end else if (start_ret) begin
          state_d = SQ_POP;
          cnt_d   = flat_mode ? CNT_LONG : CNT_SHORT;
          cnt_en  = 1'b1;
          pc_d    = '0;
          pc_en   = 1'b1;
        end
      end
      SQ_PUSH: begin
        seq_push = 1'b1;
        sh_d     = sh_q >> BYTE_W;
        sh_en    = 1'b1;
        if (cnt_q == '0) begin
          state_d = SQ_IDLE;
          pcv_d   = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      SQ_POP: begin
        seq_pop = 1'b1;
        if (cnt_q == '0) begin
          state_d = SQ_DRAIN;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      SQ_DRAIN: begin
        state_d = SQ_IDLE;
        pcv_d   = 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pcv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pcv_q   <= pcv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      pc_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (sh_en)  sh_q  <= sh_d;
      if (pc_en)  pc_q  <= pc_d;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign push_byte = sh_q[BYTE_W-1:0];
  assign pc_valid  = pcv_q;
  assign pc_value  = pc_q;
endmodule

// File: rtl/xstack_ptr.sv
module xstack_ptr #(
  parameter int               SP_W    = 8,
  parameter int               EXT_W   = 2,
  parameter int               PC_W    = 24,
  parameter logic [SP_W-1:0]  SP_RST  = 8'h07,
  parameter logic [SP_W-1:0]  ESP_RST = 8'hFC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stk_mode_10b,
  input  logic                  flat_24b,
  input  logic                  push_req,
  input  logic                  pop_req,
  input  logic [SP_W-1:0]       push_data,
  input  logic                  call_req,
  input  logic                  irq_req,
  input  logic                  ret_req,
  input  logic [PC_W-1:0]       ret_addr,
  input  logic [PC_W-1:0]       jump_target,
  input  logic                  sp_wr_en,
  input  logic [SP_W-1:0]       sp_wr_data,
  input  logic                  esp_wr_en,
  input  logic [SP_W-1:0]       esp_wr_data,
  output logic [SP_W+EXT_W-1:0] stk_addr,
  output logic                  stk_ext_sel,
  output logic                  stk_we,
  output logic [SP_W-1:0]       stk_wdata,
  output logic                  stk_re,
  input  logic [SP_W-1:0]       stk_rdata,
  output logic                  pop_valid,
  output logic [SP_W-1:0]       pop_data,
  output logic [SP_W-1:0]       sp_value,
  output logic [SP_W-1:0]       esp_value,
  output logic                  seq_busy,
  output logic                  pc_load_valid,
  output logic [PC_W-1:0]       pc_load_value,
  output logic                  req_conflict
);
  localparam int AW = SP_W + EXT_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SP_W-1:0]  sp_q, sp_d;
  logic [SP_W-1:0]  esp_q, esp_d;
  logic             sp_en, esp_en;
  logic             popv_q, err_q;
  logic             conflict, go_seq;
  logic             plain_push, plain_pop;
  logic             seq_push, seq_pop, busy;
  logic [SP_W-1:0]  seq_byte;
  logic             do_push, do_pop;
  logic [SP_W-1:0]  sp_nxt;
  logic [EXT_W-1:0] ext_nxt;
  logic [AW-1:0]    acc_addr;

  assign conflict   = push_req && pop_req;
  assign plain_push = !busy && push_req && !pop_req;
  assign plain_pop  = !busy && pop_req && !push_req;
  assign go_seq     = !busy && !push_req && !pop_req;
  assign do_push    = plain_push || seq_push;
  assign do_pop     = plain_pop || seq_pop;

  xsp_seq #(.PC_W(PC_W), .BYTE_W(SP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_call (go_seq && call_req && !irq_req),
    .start_irq  (go_seq && irq_req),
    .start_ret  (go_seq && ret_req && !irq_req && !call_req),
    .flat_mode  (flat_24b),
    .ret_addr   (ret_addr),
    .target     (jump_target),
    .rd_valid   (popv_q),
    .rd_data    (stk_rdata),
    .busy       (busy),
    .seq_push   (seq_push),
    .seq_pop    (seq_pop),
    .push_byte  (seq_byte),
    .pc_valid   (pc_load_valid),
    .pc_value   (pc_load_value)
  );

  xsp_ptr_next #(.SP_W(SP_W), .EXT_W(EXT_W)) u_ptr (
    .sp_cur    (sp_q),
    .ext_cur   (esp_q[EXT_W-1:0]),
    .wide_mode (stk_mode_10b),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .sp_nxt    (sp_nxt),
    .ext_nxt   (ext_nxt),
    .acc_addr  (acc_addr)
  );

  // next state: a register write overrides a concurrent movement
  always_comb begin
    sp_en  = sp_wr_en || do_push || do_pop;
    esp_en = esp_wr_en || ((do_push || do_pop) && stk_mode_10b);
    sp_d   = sp_wr_en  ? sp_wr_data  : sp_nxt;
    esp_d  = esp_wr_en ? esp_wr_data : {esp_q[SP_W-1:EXT_W], ext_nxt};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sp_q   <= SP_RST;
      esp_q  <= ESP_RST;
      popv_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (sp_en)  sp_q  <= sp_d;
      if (esp_en) esp_q <= esp_d;
      popv_q <= do_pop;
      err_q  <= conflict;
    end
  end

  assign stk_addr     = acc_addr;
  assign stk_ext_sel  = stk_mode_10b;
  assign stk_we       = do_push;
  assign stk_wdata    = seq_push ? seq_byte : push_data;
  assign stk_re       = do_pop;
  assign pop_valid    = popv_q;
  assign pop_data     = stk_rdata;
  assign sp_value     = sp_q;
  assign esp_value    = esp_q;
  assign seq_busy     = busy;
  assign req_conflict = err_q;
endmodule

// File: rtl/xstack_ptr_chk.sv
module xstack_ptr_chk #(
  parameter int SP_W  = 8,
  parameter int EXT_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  stk_mode_10b,
  input logic                  push_req,
  input logic                  pop_req,
  input logic                  sp_wr_en,
  input logic                  esp_wr_en,
  input logic                  do_push,
  input logic                  do_pop,
  input logic [SP_W+EXT_W-1:0] stk_addr,
  input logic                  stk_we,
  input logic                  stk_re,
  input logic                  pop_valid,
  input logic [SP_W-1:0]       sp_value,
  input logic [SP_W-1:0]       esp_value,
  input logic                  seq_busy,
  input logic                  pc_load_valid,
  input logic                  req_conflict
);
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !sp_wr_en) |=> (sp_value == $past(sp_value) + 1'b1));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !sp_wr_en) |=> (sp_value == $past(sp_value) - 1'b1));

  p_page_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && stk_mode_10b && (&sp_value) && !esp_wr_en)
    |=> (esp_value[EXT_W-1:0] == $past(esp_value[EXT_W-1:0]) + 1'b1));

  p_page_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && stk_mode_10b && (sp_value == '0) && !esp_wr_en)
    |=> (esp_value[EXT_W-1:0] == $past(esp_value[EXT_W-1:0]) - 1'b1));

  p_ext_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_mode_10b && !esp_wr_en) |=> $stable(esp_value));

  p_low_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stk_we || stk_re) && !stk_mode_10b) |-> (stk_addr[SP_W+EXT_W-1:SP_W] == '0));

  p_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |-> (!stk_we && !stk_re));

  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> req_conflict);

  p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_we, stk_re}));

  p_read_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> pop_valid);

  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |-> !seq_busy);
endmodule

bind xstack_ptr xstack_ptr_chk #(.SP_W(SP_W), .EXT_W(EXT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stk_mode_10b  (stk_mode_10b),
  .push_req      (push_req),
  .pop_req       (pop_req),
  .sp_wr_en      (sp_wr_en),
  .esp_wr_en     (esp_wr_en),
  .do_push       (do_push),
  .do_pop        (do_pop),
  .stk_addr      (stk_addr),
  .stk_we        (stk_we),
  .stk_re        (stk_re),
  .pop_valid     (pop_valid),
  .sp_value      (sp_value),
  .esp_value     (esp_value),
  .seq_busy      (seq_busy),
  .pc_load_valid (pc_load_valid),
  .req_conflict  (req_conflict)
);

// File: tb/xstack_ptr_tb_top.sv
module xstack_ptr_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic stk_mode_10b, flat_24b, push_req, pop_req, call_req, irq_req, ret_req;
  logic [7:0] push_data, sp_wr_data, esp_wr_data;
  logic [23:0] ret_addr, jump_target;
  logic sp_wr_en, esp_wr_en;
  logic [9:0] stk_addr;
  logic stk_ext_sel, stk_we, stk_re, pop_valid, seq_busy, pc_load_valid, req_conflict;
  logic [7:0] stk_wdata, stk_rdata, pop_data, sp_value, esp_value;
  logic [23:0] pc_load_value;

  always #4 clk = ~clk;

  xstack_ptr dut_i (
    .clk(clk), .rst_n(rst_n), .stk_mode_10b(stk_mode_10b), .flat_24b(flat_24b),
    .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
    .call_req(call_req), .irq_req(irq_req), .ret_req(ret_req),
    .ret_addr(ret_addr), .jump_target(jump_target),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .esp_wr_en(esp_wr_en), .esp_wr_data(esp_wr_data),
    .stk_addr(stk_addr), .stk_ext_sel(stk_ext_sel), .stk_we(stk_we), .stk_wdata(stk_wdata),
    .stk_re(stk_re), .stk_rdata(stk_rdata), .pop_valid(pop_valid), .pop_data(pop_data),
    .sp_value(sp_value), .esp_value(esp_value), .seq_busy(seq_busy),
    .pc_load_valid(pc_load_valid), .pc_load_value(pc_load_value), .req_conflict(req_conflict)
  );

  // external memories, one cycle read latency
  logic [7:0] ext_mem [0:1023];
  logic [7:0] int_mem [0:255];
  logic [7:0] rdata_q;
  always @(posedge clk) begin
    if (stk_we) begin
      if (stk_ext_sel) ext_mem[stk_addr] <= stk_wdata;
      else             int_mem[stk_addr[7:0]] <= stk_wdata;
    end
    if (stk_re) rdata_q <= stk_ext_sel ? ext_mem[stk_addr] : int_mem[stk_addr[7:0]];
  end
  assign stk_rdata = rdata_q;

  // reference model
  int  n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  int  m_sp, m_esp, m_pc, m_sh, m_pop_addr;
  bit  m_popv, m_pop_ext, m_pcv, m_err, m_ret_act, model_on;
  int  ops[$];
  int  s_ext [0:1023];
  int  s_int [0:255];

  task automatic m_eval(output int act, output int addr, output int wd);
    int nsp, nlo;
    act = 0; addr = 0; wd = 0;
    if (ops.size() > 0) begin
      act = ops[0] & 3;
      if (act == 3) act = 0;
      wd = m_sh & 255;
    end else if (push_req && pop_req) act = 0;
    else if (push_req) begin act = 1; wd = int'(push_data); end
    else if (pop_req) act = 2;
    if (act == 1) begin
      nsp = (m_sp + 1) & 255;
      nlo = (stk_mode_10b && m_sp == 255) ? (((m_esp & 3) + 1) & 3) : (m_esp & 3);
      addr = stk_mode_10b ? nlo * 256 + nsp : nsp;
    end else if (act == 2) begin
      addr = stk_mode_10b ? (m_esp & 3) * 256 + m_sp : m_sp;
    end
  endtask

  function automatic int shadow_rd();
    return m_pop_ext ? s_ext[m_pop_addr] : s_int[m_pop_addr & 255];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !model_on) begin
      m_sp = 7; m_esp = 'hFC; m_pc = 0; m_sh = 0; m_popv = 0; m_pcv = 0;
      m_err = 0; m_ret_act = 0; m_pop_addr = 0; m_pop_ext = 0; ops.delete();
    end else begin
      int act, addr, wd, n, head;
      bit was_busy;
      m_eval(act, addr, wd);
      was_busy = ops.size() > 0;
      if (m_popv && m_ret_act) m_pc = ((m_pc << 8) | shadow_rd()) & 'hFFFFFF;
      m_popv = (act == 2);
      m_pop_addr = addr; m_pop_ext = stk_mode_10b;
      m_err = push_req && pop_req;
      m_pcv = 0;
      if (act == 1) begin
        if (stk_mode_10b) s_ext[addr] = wd; else s_int[addr & 255] = wd;
        if (stk_mode_10b && m_sp == 255) m_esp = (m_esp & 'hFC) | (((m_esp & 3) + 1) & 3);
        m_sp = (m_sp + 1) & 255;
      end else if (act == 2) begin
        if (stk_mode_10b && m_sp == 0) m_esp = (m_esp & 'hFC) | (((m_esp & 3) + 3) & 3);
        m_sp = (m_sp + 255) & 255;
      end
      if (was_busy) begin
        head = ops.pop_front();
        if ((head & 3) == 1) m_sh = m_sh >> 8;
        if (head & 256) begin m_pcv = 1; m_ret_act = 0; end
      end else if (!push_req && !pop_req && (irq_req || call_req || ret_req)) begin
        n = flat_24b ? 3 : 2;
        if (irq_req || call_req) begin
          m_sh = int'(ret_addr);
          m_pc = (call_req && !irq_req && flat_24b) ? int'(jump_target) : int'(jump_target) & 'hFFFF;
          for (int i = 0; i < n; i++) ops.push_back((i == n - 1) ? 257 : 1);
        end else begin
          m_pc = 0; m_ret_act = 1;
          for (int i = 0; i < n; i++) ops.push_back(2);
          ops.push_back(259);
        end
      end
      if (sp_wr_en)  m_sp  = int'(sp_wr_data);
      if (esp_wr_en) m_esp = int'(esp_wr_data);
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && model_on) begin
      int act, addr, wd;
      m_eval(act, addr, wd);
      chk("sp_value", int'(sp_value), m_sp);
      chk("esp_value", int'(esp_value), m_esp);
      chk("seq_busy", int'(seq_busy), int'(ops.size() > 0));
      chk("stk_we", int'(stk_we), int'(act == 1));
      chk("stk_re", int'(stk_re), int'(act == 2));
      if (act != 0) begin
        chk("stk_addr", int'(stk_addr), addr);
        chk("stk_ext_sel", int'(stk_ext_sel), int'(stk_mode_10b));
      end
      if (act == 1) chk("stk_wdata", int'(stk_wdata), wd);
      chk("pop_valid", int'(pop_valid), int'(m_popv));
      if (m_popv) chk("pop_data", int'(pop_data), shadow_rd());
      chk("pc_load_valid", int'(pc_load_valid), int'(m_pcv));
      if (m_pcv) chk("pc_load_value", int'(pc_load_value), m_pc);
      chk("req_conflict", int'(req_conflict), int'(m_err));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic idle_in();
    push_req = 0; pop_req = 0; call_req = 0; irq_req = 0; ret_req = 0;
    sp_wr_en = 0; esp_wr_en = 0;
  endtask
  task automatic do_push(int b);
    push_req = 1; push_data = 8'(b); tick(); push_req = 0;
  endtask
  task automatic do_pop();
    pop_req = 1; tick(); pop_req = 0;
  endtask
  task automatic set_ptr(int sp, int esp);
    sp_wr_en = 1; sp_wr_data = 8'(sp); esp_wr_en = 1; esp_wr_data = 8'(esp);
    tick(); sp_wr_en = 0; esp_wr_en = 0;
  endtask
  task automatic seq(int kind, int ra, int tgt);
    ret_addr = 24'(ra); jump_target = 24'(tgt);
    if (kind == 0) call_req = 1; else if (kind == 1) irq_req = 1; else ret_req = 1;
    tick(); call_req = 0; irq_req = 0; ret_req = 0;
    tick(6);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin ext_mem[i] = 8'(i ^ 'h5A); s_ext[i] = (i ^ 'h5A) & 255; end
    for (int i = 0; i < 256; i++)  begin int_mem[i] = 8'(i ^ 'hA5); s_int[i] = (i ^ 'hA5) & 255; end
    rdata_q = 0; model_on = 0;
    idle_in(); stk_mode_10b = 0; flat_24b = 0; push_data = 0; sp_wr_data = 0; esp_wr_data = 0;
    ret_addr = 0; jump_target = 0;
    rst_n = 0; tick(4); rst_n = 1; tick(3);
    model_on = 1; tick();
    cur_req = "R1";
    chk("reset sp", int'(sp_value), 'h07);
    chk("reset esp", int'(esp_value), 'hFC);
    chk("reset busy", int'(seq_busy), 0);
    tick(2);

    cur_req = "R12";  // write overrides a concurrent push
    sp_wr_en = 1; sp_wr_data = 8'hFC; push_req = 1; push_data = 8'h11;
    tick(); idle_in(); tick();
    chk("override sp", int'(sp_value), 'hFC);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) do_push('h30 + i);
    for (int i = 0; i < 5; i++) do_pop();
    tick(2);

    cur_req = "R5";
    do_push('hC3); do_pop(); do_pop(); tick(2);

    cur_req = "R3";
    stk_mode_10b = 1; set_ptr('hFE, 'hFD);
    for (int i = 0; i < 3; i++) do_push('h70 + i);
    set_ptr('hFF, 'hFF); do_push('h99); tick();
    chk("page wrap esp", int'(esp_value), 'hFC);

    cur_req = "R4";
    do_pop(); do_pop(); set_ptr('h01, 'hFE);
    for (int i = 0; i < 3; i++) do_pop();
    tick(2);

    cur_req = "R6";
    push_req = 1; pop_req = 1; call_req = 1; tick(); idle_in(); tick(3);

    cur_req = "R7";
    stk_mode_10b = 0; flat_24b = 0; set_ptr('h40, 'hFC);
    seq(0, 'hABCDEF, 'h123456);
    flat_24b = 1; stk_mode_10b = 1; set_ptr('hFE, 'hFD);
    seq(0, 'h87654B, 'h3A1234);

    cur_req = "R9";
    seq(2, 0, 0);
    flat_24b = 0; stk_mode_10b = 0; set_ptr('h40, 'hFC);
    seq(0, 'h00BEEF, 'h00CAFE); seq(2, 0, 0);

    cur_req = "R8";
    flat_24b = 1; stk_mode_10b = 1; set_ptr('hFF, 'hFF);
    seq(1, 'h5A6B7C, 'hFF0030);
    seq(2, 0, 0);

    cur_req = "R10";
    ret_addr = 24'h010203; jump_target = 24'h040506; call_req = 1; tick(); call_req = 0;
    push_req = 1; push_data = 8'hEE; tick(); push_req = 0;
    ret_req = 1; irq_req = 1; tick(); ret_req = 0; irq_req = 0;
    pop_req = 1; tick(); idle_in(); tick(5);

    cur_req = "R11";
    ret_addr = 24'h111111; jump_target = 24'h222222;
    push_req = 1; push_data = 8'h5C; call_req = 1; tick(); idle_in(); tick(5);
    irq_req = 1; call_req = 1; tick(); idle_in(); tick(6);
    call_req = 1; ret_req = 1; tick(); idle_in(); tick(6);
    ret_req = 1; tick(); idle_in(); tick(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule